// File: doc/BRIEF.md
# Processor System-Control Exception Unit

This unit is the control-register and trap logic of a small 32-bit in-order core. The commit stage presents the PC of the instruction it is retiring, a flag marking that instruction as a branch delay slot, an optional exception request with a 5-bit code, and the instruction word itself. A level-sensitive external interrupt line feeds a pending flag. The unit keeps three architectural registers: status, cause and saved PC. It decides in the same cycle whether fetch must be redirected, and where to.

Entry into a trap records the code and the delay-slot origin, saves the restart PC and raises the exception-level flag. The return instruction sends fetch back to the saved PC and drops that flag. Two move instructions give the core read and write access to the control registers. Control register 12 is the status register. Registers 13 and 14 can be read. Every other number reads as zero.

Top module: `sysctl_unit`

## Requirements
- R1: While reset is held, status reads 0x0040_0000 (only the boot-vector bit, bit 22, set), cause and saved PC read zero, and no redirect, reservation clear or register write is signalled.
- R2: A trap taken while status bit 1 is clear sets cause to the code shifted left by 2, with bit 31 equal to the delay-slot flag. It sets the saved PC to pc_i, or to pc_i minus 4 when the delay-slot flag is set. Both are visible one cycle after the trap.
- R3: Every trap sets status bit 1 on the next cycle. In the trap cycle itself it asserts ll_clear_o.
- R4: A trap taken while status bit 1 is already set keeps the saved PC and cause bit 31. Only cause bits 6:2 take the new code.
- R5: In a trap cycle, redirect_o is high and redirect_pc_o is 0xBFC0_0380 when status bit 22 is set, or 0x8000_0180 when it is clear.
- R6: A high irq_i sets a pending flag on the next edge. The flag stays set until it is taken. It is taken as a trap with code 0 in a cycle where it is set, status bit 0 is 1, status bit 1 is 0, and no exception request is present. Taking it clears the flag unless irq_i is still high.
- R7: A pipeline exception request has priority over a pending interrupt. Any trap cycle suppresses the effects of the instruction presented in that cycle: no register write, no status write, no return.
- R8: A read instruction has bits 31:26 = 010000, bits 25:21 = 00000 and bits 10:0 zero. It raises gpr_we_o in the same cycle, with gpr_waddr_o = bits 20:16. gpr_wdata_o comes from the register numbered by bits 15:11: 12 gives status, 13 gives cause, 14 gives the saved PC, and any other number gives zero.
- R9: A write instruction uses the same format with bits 25:21 = 00100. When bits 15:11 equal 12, status takes rt_value_i on the next cycle. Writes to any other number change no register.
- R10: The return instruction has bits 31:26 = 010000, bits 25:21 = 10000 and bits 5:0 = 0x18. It raises redirect_o with redirect_pc_o equal to the saved PC in the same cycle, and clears status bit 1 on the next cycle.
- R11: A word with the control opcode but nonzero bits 10:0 and bits 25:21 equal to 00000 or 00100 has no effect. The same holds for any instruction while instr_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Pipeline exception request for the retiring instruction |
| exc_code_i | input | 5 | Exception code |
| pc_i | input | 32 | PC of the retiring instruction |
| in_bd_i | input | 1 | Retiring instruction sits in a branch delay slot |
| irq_i | input | 1 | External interrupt request, level |
| instr_valid_i | input | 1 | instr_i holds a retiring instruction |
| instr_i | input | 32 | Retiring instruction word |
| rt_value_i | input | 32 | Value of the source general register for a write |
| redirect_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | 32 | Trap vector or return target |
| ll_clear_o | output | 1 | Clear the load-linked reservation |
| gpr_we_o | output | 1 | Write a control-register value into a general register |
| gpr_waddr_o | output | 5 | General register index for that write |
| gpr_wdata_o | output | 32 | Control-register value being read |
| status_o | output | 32 | Status register |
| cause_o | output | 32 | Cause register |
| epc_o | output | 32 | Saved exception PC |

## Verification
Redirect, reservation clear and general-register write are combinational, so each is due in the same cycle as its stimulus. Status, cause and saved PC are due one edge later. An interrupt needs one edge to become pending and can be taken in the cycle after that. The bench drives inputs at the falling edge, compares the same-cycle outputs just after, and compares the register outputs at the following falling edge against a model that advances exactly once per rising edge.

// File: rtl/scu_pkg.sv
package scu_pkg;
  localparam int XLEN      = 32;
  localparam int CODE_W    = 5;
  localparam int RIDX_W    = 5;

  localparam logic [5:0] OPC_SYSCTL = 6'b010000;
  localparam logic [4:0] SUB_READ   = 5'h00;
  localparam logic [4:0] SUB_WRITE  = 5'h04;
  localparam logic [4:0] SUB_CO     = 5'h10;
  localparam logic [5:0] FN_RETURN  = 6'h18;

  localparam logic [RIDX_W-1:0] CR_STATUS = 5'd12;
  localparam logic [RIDX_W-1:0] CR_CAUSE  = 5'd13;
  localparam logic [RIDX_W-1:0] CR_EPC    = 5'd14;

  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int CA_BD  = 31;
  localparam int CA_LSB = 2;

  localparam logic [XLEN-1:0] BASE_BOOT  = 32'hBFC0_0200;
  localparam logic [XLEN-1:0] BASE_RUN   = 32'h8000_0000;
  localparam logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0180;
  localparam logic [XLEN-1:0] STATUS_RST = 32'h0040_0000;

  typedef struct packed {
    logic              rd_op;
    logic              wr_op;
    logic              ret_op;
    logic [RIDX_W-1:0] gpr;
    logic [RIDX_W-1:0] creg;
  } ctl_op_t;
endpackage

// File: rtl/scu_decode.sv
module scu_decode
  import scu_pkg::*;
(
  input  logic            valid_i,
  input  logic [XLEN-1:0] instr_i,
  output ctl_op_t         op_o
);
  logic [5:0] opc;
  logic [4:0] sub;
  logic       low_zero;

  assign opc      = instr_i[31:26];
  assign sub      = instr_i[25:21];
  assign low_zero = (instr_i[10:0] == 11'd0);

  always_comb begin
    op_o      = '0;
    op_o.gpr  = instr_i[20:16];
    op_o.creg = instr_i[15:11];
    if (valid_i && opc == OPC_SYSCTL) begin
      op_o.rd_op  = low_zero && (sub == SUB_READ);
      op_o.wr_op  = low_zero && (sub == SUB_WRITE);
      op_o.ret_op = (sub == SUB_CO) && (instr_i[5:0] == FN_RETURN);
    end
  end
endmodule

// File: rtl/scu_irq.sv
module scu_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic ie_i,
  input  logic exl_i,
  input  logic block_i,
  output logic take_o
);
  logic pend_q, pend_d;

  assign take_o = pend_q && ie_i && !exl_i && !block_i;

  always_comb begin
    pend_d = (pend_q && !take_o) || irq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (ie_i && !exl_i && !block_i));
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take_o) |=> pend_q);
endmodule

// File: rtl/scu_regs.sv
module scu_regs
  import scu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              bd_i,
  input  logic              ret_i,
  input  logic              st_we_i,
  input  logic [XLEN-1:0]   st_wdata_i,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o
);
  logic [XLEN-1:0] status_q, status_d;
  logic [XLEN-1:0] cause_q, cause_d;
  logic [XLEN-1:0] epc_q, epc_d;
  logic            upd_en;

  assign upd_en = entry_i || ret_i || st_we_i;

  always_comb begin
    status_d = status_q;
    cause_d  = cause_q;
    epc_d    = epc_q;
    if (entry_i) begin
      if (!status_q[ST_EXL]) begin
        cause_d = '0;
        cause_d[CA_BD] = bd_i;
        epc_d = bd_i ? (pc_i - 32'd4) : pc_i;
      end
      cause_d[CA_LSB +: CODE_W] = code_i;
      status_d[ST_EXL] = 1'b1;
    end else if (ret_i) begin
      status_d[ST_EXL] = 1'b0;
    end else if (st_we_i) begin
      status_d = st_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
    end else if (upd_en) begin
      status_q <= status_d;
      cause_q  <= cause_d;
      epc_q    <= epc_d;
    end
  end

  assign status_o = status_q;
  assign cause_o  = cause_q;
  assign epc_o    = epc_q;

  p_exl_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> status_q[ST_EXL]);
  p_epc_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_i && status_q[ST_EXL]) |=> ($stable(epc_q) && $stable(cause_q[CA_BD])));
  p_code_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    entry_i |=> (cause_q[CA_LSB +: CODE_W] == $past(code_i)));
  p_ret_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !entry_i) |=> !status_q[ST_EXL]);
endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
  import scu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              in_bd_i,
  input  logic              irq_i,
  input  logic              instr_valid_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   rt_value_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic              ll_clear_o,
  output logic              gpr_we_o,
  output logic [RIDX_W-1:0] gpr_waddr_o,
  output logic [XLEN-1:0]   gpr_wdata_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o
);
  ctl_op_t           op;
  logic              irq_take, entry, ret_do, rd_do, st_we;
  logic [CODE_W-1:0] entry_code;
  logic [XLEN-1:0]   vector;
  logic [XLEN-1:0]   rd_val;

  scu_decode u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .op_o    (op)
  );

  scu_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq_i),
    .ie_i    (status_o[ST_IE]),
    .exl_i   (status_o[ST_EXL]),
    .block_i (exc_req_i),
    .take_o  (irq_take)
  );

  assign entry      = exc_req_i || irq_take;
  assign entry_code = exc_req_i ? exc_code_i : '0;
  assign ret_do     = op.ret_op && !entry;
  assign rd_do      = op.rd_op && !entry;
  assign st_we      = op.wr_op && !entry && (op.creg == CR_STATUS);

  scu_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_i    (entry),
    .code_i     (entry_code),
    .pc_i       (pc_i),
    .bd_i       (in_bd_i),
    .ret_i      (ret_do),
    .st_we_i    (st_we),
    .st_wdata_i (rt_value_i),
    .status_o   (status_o),
    .cause_o    (cause_o),
    .epc_o      (epc_o)
  );

  assign vector = (status_o[ST_BEV] ? BASE_BOOT : BASE_RUN) + VEC_OFFSET;

  always_comb begin
    unique case (op.creg)
      CR_STATUS: rd_val = status_o;
      CR_CAUSE:  rd_val = cause_o;
      CR_EPC:    rd_val = epc_o;
      default:   rd_val = '0;
    endcase
  end

  assign redirect_o    = entry || ret_do;
  assign redirect_pc_o = entry ? vector : epc_o;
  assign ll_clear_o    = entry;
  assign gpr_we_o      = rd_do;
  assign gpr_waddr_o   = op.gpr;
  assign gpr_wdata_o   = rd_val;

  p_vec_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && ll_clear_o) |-> (redirect_pc_o[11:0] inside {12'h180, 12'h380}));
  p_trap_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ll_clear_o |-> !gpr_we_o);
  p_ret_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !ll_clear_o) |-> (redirect_pc_o == epc_o));
endmodule

// File: tb/sim_sysctl_unit.sv
module sim_sysctl_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req, in_bd, irq, ivalid;
  logic [4:0]  exc_code;
  logic [31:0] pc, instr, rtv;
  logic        redirect, llc, gwe;
  logic [31:0] rpc, gwd, st, ca, ep;
  logic [4:0]  gwa;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_unit u0 (
    .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req), .exc_code_i(exc_code),
    .pc_i(pc), .in_bd_i(in_bd), .irq_i(irq), .instr_valid_i(ivalid),
    .instr_i(instr), .rt_value_i(rtv), .redirect_o(redirect),
    .redirect_pc_o(rpc), .ll_clear_o(llc), .gpr_we_o(gwe),
    .gpr_waddr_o(gwa), .gpr_wdata_o(gwd), .status_o(st), .cause_o(ca),
    .epc_o(ep)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  logic [31:0] m_st, m_ca, m_ep;
  logic        m_pd;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] i_rd(logic [4:0] rt, logic [4:0] rd);
    return {6'b010000, 5'h00, rt, rd, 11'd0};
  endfunction
  function automatic logic [31:0] i_wr(logic [4:0] rt, logic [4:0] rd);
    return {6'b010000, 5'h04, rt, rd, 11'd0};
  endfunction
  localparam logic [31:0] I_RET = 32'h4200_0018;

  task automatic idle();
    exc_req = 0; exc_code = '0; in_bd = 0; irq = 0;
    ivalid = 0; instr = '0; rtv = '0;
  endtask

  // One cycle: inputs are driven, then compare and advance the model.
  task automatic step();
    logic        take, ent, ret, rdo, wst;
    logic [4:0]  code, rd;
    logic [31:0] vec, rv, n_st, n_ca, n_ep;
    logic        opc_ok, low0;
    #1;
    opc_ok = ivalid && instr[31:26] == 6'b010000;
    low0   = instr[10:0] == 11'd0;
    rd     = instr[15:11];
    take = m_pd && m_st[0] && !m_st[1] && !exc_req;       // R6
    ent  = exc_req || take;                                 // R7 priority
    code = exc_req ? exc_code : 5'd0;
    ret  = !ent && opc_ok && instr[25:21] == 5'h10 && instr[5:0] == 6'h18;
    rdo  = !ent && opc_ok && low0 && instr[25:21] == 5'h00;
    wst  = !ent && opc_ok && low0 && instr[25:21] == 5'h04 && rd == 5'd12;
    vec  = m_st[22] ? 32'hBFC0_0380 : 32'h8000_0180;
    rv   = (rd == 5'd12) ? m_st : (rd == 5'd13) ? m_ca : (rd == 5'd14) ? m_ep : 32'd0;
    chk("redirect", {31'd0, redirect}, {31'd0, ent || ret});
    if (ent)      chk("trap vector (R5)", rpc, vec);
    else if (ret) chk("return target (R10)", rpc, m_ep);
    chk("ll_clear (R3)", {31'd0, llc}, {31'd0, ent});
    chk("gpr_we (R8)", {31'd0, gwe}, {31'd0, rdo});
    if (rdo) begin
      chk("gpr_waddr (R8)", {27'd0, gwa}, {27'd0, instr[20:16]});
      chk("gpr_wdata (R8)", gwd, rv);
    end
    n_st = m_st; n_ca = m_ca; n_ep = m_ep;
    if (ent) begin
      if (!m_st[1]) begin
        n_ca = {in_bd, 31'd0};
        n_ep = in_bd ? pc - 32'd4 : pc;
      end
      n_ca[6:2] = code;
      n_st[1] = 1'b1;
    end else if (ret) n_st[1] = 1'b0;
    else if (wst) n_st = rtv;
    @(posedge clk);
    #1;
    m_pd = (m_pd && !take) || irq;
    m_st = n_st; m_ca = n_ca; m_ep = n_ep;
    @(negedge clk);
    chk("status", st, m_st);
    chk("cause", ca, m_ca);
    chk("epc", ep, m_ep);
  endtask

  task automatic trap(logic [4:0] c, logic [31:0] p, logic bd);
    idle(); exc_req = 1; exc_code = c; pc = p; in_bd = bd; step(); idle();
  endtask
  task automatic wr_status(logic [31:0] v);
    idle(); ivalid = 1; instr = i_wr(5'd3, 5'd12); rtv = v; step(); idle();
  endtask
  task automatic do_ret();
    idle(); ivalid = 1; instr = I_RET; step(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired before the bench finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; pc = 32'h100; idle();
    m_st = 32'h0040_0000; m_ca = 0; m_ep = 0; m_pd = 0;
    repeat (2) @(negedge clk);
    tag = "R1";
    chk("reset status", st, 32'h0040_0000);
    chk("reset cause", ca, 32'd0);
    chk("reset epc", ep, 32'd0);
    chk("reset redirect", {31'd0, redirect}, 32'd0);
    chk("reset ll_clear", {31'd0, llc}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    tag = "R2";  trap(5'd4, 32'h0000_1000, 1'b1);   // delay slot: epc = pc-4
    chk("epc from delay slot", ep, 32'h0000_0FFC);
    chk("cause bd+code", ca, 32'h8000_0010);
    tag = "R4";  trap(5'd9, 32'h0000_2000, 1'b0);   // nested: epc and bd kept
    chk("nested epc kept", ep, 32'h0000_0FFC);
    chk("nested cause", ca, 32'h8000_0024);
    tag = "R10"; do_ret();
    chk("exl cleared", {31'd0, st[1]}, 32'd0);
    tag = "R9";  wr_status(32'h0000_0001);
    chk("status written", st, 32'h0000_0001);
    tag = "R5";  trap(5'd12, 32'h0000_3000, 1'b0);
    tag = "R3";  chk("exl set after trap", {31'd0, st[1]}, 32'd1);
    do_ret();

    tag = "R6";  wr_status(32'd0);
    irq = 1; step(); idle();
    repeat (3) step();                                   // masked, stays pending
    wr_status(32'h0000_0001);
    pc = 32'h0000_4000; step();                          // taken here, code 0
    chk("irq cause", ca, 32'd0);
    chk("irq epc", ep, 32'h0000_4000);
    do_ret();

    tag = "R7";  irq = 1; step(); idle();
    exc_req = 1; exc_code = 5'd10; pc = 32'h0000_5000;
    ivalid = 1; instr = i_wr(5'd1, 5'd12); rtv = 32'h0;
    step(); idle();
    chk("exception code wins", ca, 32'h0000_0028);
    chk("suppressed status write", st, 32'h0000_0003);
    do_ret();
    step();                                              // pending irq now taken

    tag = "R8";
    for (int k = 10; k < 17; k++) begin
      do_ret(); idle(); ivalid = 1; instr = i_rd(5'(k), 5'(k)); step(); idle();
    end
    tag = "R11";
    ivalid = 1; instr = i_rd(5'd2, 5'd12) | 32'h1; step();
    instr = i_wr(5'd2, 5'd12) | 32'h40; rtv = 32'hFFFF_FFFF; step();
    instr = i_wr(5'd2, 5'd5); step();
    instr = i_rd(5'd2, 5'd5); step();
    ivalid = 0; instr = i_wr(5'd2, 5'd12); step();
    idle();

    tag = "R2";
    for (int i = 0; i < 800; i++) begin
      int sel;
      idle();
      sel      = $urandom_range(0, 9);
      exc_req  = ($urandom_range(0, 7) == 0);
      exc_code = 5'($urandom);
      pc       = {$urandom, 2'b00} >> 2 << 2;
      in_bd    = $urandom_range(0, 1) == 1;
      irq      = ($urandom_range(0, 5) == 0);
      ivalid   = $urandom_range(0, 5) != 0;
      rtv      = $urandom & 32'h0040_0003;
      case (sel)
        0, 1:    instr = i_rd(5'($urandom), 5'($urandom_range(11, 15)));
        2, 3:    instr = i_wr(5'($urandom), 5'd12);
        4:       instr = i_wr(5'($urandom), 5'($urandom));
        5, 6:    instr = I_RET;
        default: instr = $urandom;
      endcase
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule